// File: doc/BRIEF.md
# Dual-Clock Relative Frequency Detector

This block works out which of two free-running, unrelated clocks runs faster: the write clock or the read clock. When master reset is released, each clock drives its own counter. A counter stops once it has seen 2^CNT_W edges of its own clock. Each domain's "finished" flag passes through a two-flop synchronizer into the configuration clock domain. The first flag to arrive there decides the result. If both flags arrive in the same cycle, the write clock wins.

The result is held in a single fast-clock bit. A value of 1 means the write clock is the faster one. Software can read this bit back, and can overwrite it through a small register port, at one address. Every change in the bit's value starts a settle window. During that window `busy` tells the surrounding FIFO logic not to issue reads or writes. A `meas_done` flag reports that the race has finished. Correct results assume both clocks keep running and that their frequency ratio stays within 0.5 to 2.

Top module: `clk_race_detect`

## Requirements
- R1: While `mrst` is high, `meas_done`, `wclk_faster` and `busy` are 0, and `cfg_rdata` is 0.
- R2: After `mrst` falls, each domain counter must see 2^CNT_W edges of its own clock before its completion is forwarded. `meas_done` therefore stays 0 for at least (2^CNT_W - 2) periods of the faster clock.
- R3: If the write-clock counter's completion reaches the configuration domain first, `meas_done` rises and `wclk_faster` becomes 1.
- R4: If the read-clock counter's completion reaches the configuration domain first, `meas_done` rises and `wclk_faster` stays 0.
- R5: If both completions reach the configuration domain in the same `cfg_clk` cycle, `wclk_faster` becomes 1.
- R6: `meas_done` stays 1 until the next master reset. Once set, the measured result is never re-applied.
- R7: When `cfg_addr` equals CFG_ADDR (default 4'hA), `cfg_rdata` carries `wclk_faster` at bit FAST_BIT (default 0) and 0 in every other bit. At any other address `cfg_rdata` is 0.
- R8: A `cfg_we` cycle with `cfg_addr` equal to CFG_ADDR, taken while `meas_done` is 1, loads `cfg_wdata[FAST_BIT]` into `wclk_faster` on that clock edge.
- R9: A write to any other address, or any write taken while `meas_done` is 0, leaves `wclk_faster` unchanged.
- R10: After every clock edge that changes `wclk_faster`, `busy` is 1 for exactly SETTLE_CYC cycles. Updates that leave the value unchanged do not raise `busy`.
- R11: A change of `wclk_faster` while `busy` is high restarts the settle window at its full length.
- R12: A new master reset clears the result and both counters, and the next race repeats the measurement from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; drives the write-side counter |
| rd_clk | input | 1 | Read clock; drives the read-side counter |
| cfg_clk | input | 1 | Configuration/evaluation clock |
| mrst | input | 1 | Master reset, active high, asynchronous assert |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address for both read and write |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data, combinational from `cfg_addr` |
| wclk_faster | output | 1 | Fast-clock bit: 1 means the write clock is faster |
| meas_done | output | 1 | Measurement complete; sticky until reset |
| busy | output | 1 | Settle window active; hold off FIFO accesses |

## Verification
The bench builds the block with CNT_W = 5 and SETTLE_CYC = 6. With these values each race finishes within about forty slow-clock edges, so one run covers a write-faster race, a read-faster race and an exact tie, each started by its own master reset. The short settle window lets the bench count every `busy` cycle exactly. It also makes room to restart the window in its middle and to see the full length again, rather than the remainder.

// File: rtl/clk_race_detect.sv
module clk_race_detect #(
  parameter int CNT_W      = 10,
  parameter int SETTLE_CYC = 64,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'hA,
  parameter int FAST_BIT   = 0
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              cfg_clk,
  input  logic              mrst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              wclk_faster,
  output logic              meas_done,
  output logic              busy
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W:0]   wcnt, rcnt;
  logic [1:0]       wsync, rsync;
  logic [SET_W-1:0] settle;
  logic             hit, sw_wr, fast_nxt;

  always_ff @(posedge wr_clk or posedge mrst)
    if (mrst)              wcnt <= '0;
    else if (!wcnt[CNT_W]) wcnt <= wcnt + 1'b1;

  always_ff @(posedge rd_clk or posedge mrst)
    if (mrst)              rcnt <= '0;
    else if (!rcnt[CNT_W]) rcnt <= rcnt + 1'b1;

  always_ff @(posedge cfg_clk or posedge mrst)
    if (mrst) begin
      wsync <= '0;
      rsync <= '0;
    end else begin
      wsync <= {wsync[0], wcnt[CNT_W]};
      rsync <= {rsync[0], rcnt[CNT_W]};
    end

  assign hit      = !meas_done && (wsync[1] || rsync[1]);
  assign sw_wr    = cfg_we && meas_done && (cfg_addr == CFG_ADDR);
  assign fast_nxt = hit   ? wsync[1] :
                    sw_wr ? cfg_wdata[FAST_BIT] : wclk_faster;

  always_ff @(posedge cfg_clk or posedge mrst)
    if (mrst) begin
      meas_done   <= 1'b0;
      wclk_faster <= 1'b0;
      settle      <= '0;
    end else begin
      meas_done   <= meas_done | hit;
      wclk_faster <= fast_nxt;
      if (fast_nxt != wclk_faster) settle <= SET_W'(SETTLE_CYC);
      else if (settle != '0)       settle <= settle - 1'b1;
    end

  assign busy      = (settle != '0);
  assign cfg_rdata = (cfg_addr == CFG_ADDR) ?
                     ({{(DATA_W-1){1'b0}}, wclk_faster} << FAST_BIT) : '0;
endmodule

module clk_race_detect_chk #(
  parameter int SETTLE_CYC = 64
) (
  input logic cfg_clk,
  input logic mrst,
  input logic wclk_faster,
  input logic meas_done,
  input logic busy
);
  localparam int Q_W = $clog2(SETTLE_CYC + 1) + 1;

  logic           prev_fast;
  logic [Q_W-1:0] quiet;
  logic           changed;

  assign changed = (wclk_faster != prev_fast);

  always_ff @(posedge cfg_clk or posedge mrst)
    if (mrst) begin
      prev_fast <= 1'b0;
      quiet     <= '0;
    end else begin
      prev_fast <= wclk_faster;
      if (changed)                    quiet <= '0;
      else if (quiet < Q_W'(SETTLE_CYC)) quiet <= quiet + 1'b1;
    end

  // R6
  done_sticky_chk: assert property (@(posedge cfg_clk) disable iff (mrst)
    meas_done |=> meas_done);

  // R9
  idle_before_done_chk: assert property (@(posedge cfg_clk) disable iff (mrst)
    !meas_done |-> (!wclk_faster && !busy));

  // R10
  change_sets_busy_chk: assert property (@(posedge cfg_clk) disable iff (mrst)
    changed |-> busy);

  // R10
  busy_needs_change_chk: assert property (@(posedge cfg_clk) disable iff (mrst)
    $rose(busy) |-> changed);

  // R11
  busy_bounded_chk: assert property (@(posedge cfg_clk) disable iff (mrst)
    (!changed && quiet >= Q_W'(SETTLE_CYC - 1)) |-> !busy);
endmodule

bind clk_race_detect clk_race_detect_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .cfg_clk     (cfg_clk),
  .mrst        (mrst),
  .wclk_faster (wclk_faster),
  .meas_done   (meas_done),
  .busy        (busy)
);

// File: tb/clk_race_detect_tb.sv
`timescale 1ns/1ps
module clk_race_detect_tb;
  localparam int CNT_W = 5, SETTLE = 6, ADDR_W = 4, DATA_W = 8, FB = 0;
  localparam logic [ADDR_W-1:0] CA = 4'hA;

  logic cfg_clk = 0, wclk_i = 0, rclk_i = 0, tie = 0;
  int   wh = 3, rh = 5;
  logic mrst = 1, cfg_we = 0;
  logic [ADDR_W-1:0] cfg_addr = CA;
  logic [DATA_W-1:0] cfg_wdata = 0, cfg_rdata;
  logic wclk_faster, meas_done, busy;
  logic wr_clk;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 cfg_clk = ~cfg_clk;
  initial forever #(wh) wclk_i = ~wclk_i;
  initial forever #(rh) rclk_i = ~rclk_i;
  assign wr_clk = tie ? rclk_i : wclk_i;

  clk_race_detect #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE), .ADDR_W(ADDR_W),
                    .DATA_W(DATA_W), .CFG_ADDR(CA), .FAST_BIT(FB)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rclk_i), .cfg_clk(cfg_clk), .mrst(mrst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wclk_faster(wclk_faster), .meas_done(meas_done),
    .busy(busy));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge cfg_clk); mrst = 1;
    repeat (4) @(negedge cfg_clk);
    #1 mrst = 0;
    @(negedge cfg_clk);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!meas_done && n < 500) begin @(negedge cfg_clk); n++; end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge cfg_clk); end
  endtask

  task automatic cfg_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge cfg_clk);
    cfg_we = 0; cfg_addr = CA;
  endtask

  task automatic t_reset();
    @(negedge cfg_clk);
    cfg_addr = CA;
    chk("R1 done", meas_done, 0);
    chk("R1 fast", wclk_faster, 0);
    chk("R1 busy", busy, 0);
    chk("R1 rdata", cfg_rdata, 0);
  endtask

  task automatic t_write_faster();
    int n;
    wh = 3; rh = 5; tie = 0;
    do_reset();
    #((((1 << CNT_W) - 3) * 6));
    chk("R2 done early", meas_done, 0);
    wait_done();
    chk("R3 done", meas_done, 1);
    chk("R3 fast", wclk_faster, 1);
    count_busy(n);
    chk("R10 busy after measure", n, SETTLE);
    cfg_addr = CA; #1;
    chk("R7 rdata at addr", cfg_rdata, 1 << FB);
    cfg_addr = 4'h3; #1;
    chk("R7 rdata other addr", cfg_rdata, 0);
    cfg_addr = CA;
    @(negedge cfg_clk);
    cfg_write(CA, 8'h01);
    chk("R10 same value no busy", busy, 0);
    chk("R10 same value fast", wclk_faster, 1);
    cfg_write(4'h3, 8'h00);
    chk("R9 wrong addr", wclk_faster, 1);
    chk("R9 wrong addr busy", busy, 0);
    cfg_write(CA, 8'h00);
    chk("R8 override to 0", wclk_faster, 0);
    count_busy(n);
    chk("R10 busy after write", n, SETTLE);
    @(negedge cfg_clk);
    cfg_write(CA, 8'h01);
    chk("R8 override to 1", wclk_faster, 1);
    repeat (2) @(negedge cfg_clk);
    cfg_write(CA, 8'h00);
    count_busy(n);
    chk("R11 restarted window", n, SETTLE);
    repeat (60) @(negedge cfg_clk);
    chk("R6 done sticky", meas_done, 1);
    chk("R6 result kept", wclk_faster, 0);
  endtask

  task automatic t_read_faster();
    wh = 5; rh = 3; tie = 0;
    do_reset();
    cfg_write(CA, 8'h01);
    chk("R9 write before done", wclk_faster, 0);
    wait_done();
    chk("R4 done", meas_done, 1);
    chk("R4 fast", wclk_faster, 0);
    chk("R10 no change no busy", busy, 0);
  endtask

  task automatic t_tie();
    rh = 4; tie = 1;
    do_reset();
    wait_done();
    chk("R5 tie fast", wclk_faster, 1);
    do_reset();
    chk("R12 done cleared", meas_done, 0);
    chk("R12 fast cleared", wclk_faster, 0);
    #((((1 << CNT_W) - 3) * 8));
    chk("R12 recount", meas_done, 0);
    wait_done();
    chk("R12 remeasure", wclk_faster, 1);
  endtask

  initial begin
    t_reset();
    t_write_faster();
    t_read_faster();
    t_tie();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule